// File: doc/BRIEF.md
# LPC bus cycle monitor

This block listens passively to a Low-Pin-Count bus and rebuilds the nibble-serial target cycles that travel on it. On every rising clock edge it samples the frame strobe, the bus reset and the 4-bit multiplexed address/data lines. It follows each I/O or memory cycle through its phases: start code, cycle type, address, turnaround, sync with wait states, and data. When a cycle finishes it presents one record, holding the cycle kind, direction, address, data byte and the final sync code, together with a one-clock valid pulse.

The monitor never drives the bus. It only reports what it sees, and it raises one-clock warning pulses for protocol problems. These cover reserved cycle types, bad turnaround values, frame strobes that cut a cycle short, start codes other than a target cycle, and nibble changes while the frame strobe is held low. It is meant to sit beside a bus-facing block as a debug or coverage tap. The record and the warnings would be logged or counted by surrounding logic.

Top module: `lpc_cycle_mon`

## Requirements
- R1: While `rst_n` is low, or one clock after a sample with `bus_rst_n` low, the monitor is idle. A cycle in progress is discarded with no record, and nibbles that follow with the frame strobe high are ignored.
- R2: A cycle's start code is the nibble sampled on the last clock with `bus_frame_n` low. Only code 0000 (target cycle) goes on to cycle-type decoding. The cycle-type nibble is taken on the first clock with the frame strobe high.
- R3: If the nibble differs from the previous one while the frame strobe stays low on consecutive clocks, `warn_lad_chg` pulses for one clock after that sample.
- R4: Cycle-type nibble: bits [3:2] select the kind (00 I/O, 01 memory, 10 DMA, 11 reserved), bit 1 is 1 for a write, and bit 0 is ignored. A reserved kind pulses `warn_ctype` and produces no record. A DMA kind produces neither a record nor a warning.
- R5: An I/O cycle takes 4 address nibbles and a memory cycle takes 8, most significant first. `rec_addr` bits above bit 15 are zero for I/O records.
- R6: Write cycle order: address, 2 data nibbles, 2 turnaround clocks, sync, 2 turnaround clocks.
- R7: Read cycle order: address, 2 turnaround clocks, sync, 2 data nibbles, 2 turnaround clocks. In both directions the data byte arrives low nibble first.
- R8: Each turnaround clock whose nibble is not 1111 pulses `warn_tar` for one clock. The cycle still completes.
- R9: Sync 0101 (short wait) and 0110 (long wait) may repeat for any number of clocks. Sync 0000 (ready) moves the cycle on.
- R10: Any other sync value ends the cycle at once. It emits a record with `rec_err` = 1 and `rec_sync` equal to that value. Completed cycles carry `rec_err` = 0 and `rec_sync` = 0000.
- R11: A low frame strobe during the address, data, turnaround or sync phases pulses `abort_seen`, drops the cycle without a record, and starts new start-code detection on that very clock.
- R12: Start code 1111 pulses `abort_seen`. Any start code other than 0000 or 1111 pulses `other_start` with the code on `other_code`. Neither produces a record.
- R13: `rec_valid` is high for exactly one clock, right after the edge that samples the last turnaround nibble or an ending sync value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low monitor reset |
| bus_rst_n | input | 1 | Bus reset, active low, sampled synchronously |
| bus_frame_n | input | 1 | Frame strobe, active low |
| bus_nib | input | 4 | Multiplexed address/data nibble |
| rec_valid | output | 1 | One-clock pulse: record fields valid |
| rec_mem | output | 1 | Record kind: 1 memory, 0 I/O |
| rec_wr | output | 1 | Record direction: 1 write |
| rec_addr | output | 32 | Record address |
| rec_data | output | 8 | Record data byte |
| rec_sync | output | 4 | Final sync code of the cycle |
| rec_err | output | 1 | Cycle ended on an error or reserved sync |
| warn_lad_chg | output | 1 | Nibble changed while frame strobe held low |
| warn_ctype | output | 1 | Reserved cycle type seen |
| warn_tar | output | 1 | Turnaround nibble was not 1111 |
| abort_seen | output | 1 | Mid-cycle frame strobe or start code 1111 |
| other_start | output | 1 | Start code not handled as a target cycle |
| other_code | output | 4 | The start code reported with `other_start` |

## Verification
Every result of this block is registered once. A record or warning caused by the nibble sampled at rising edge k is visible right after edge k and gone after edge k+1. The bench drives each nibble at the falling edge, then reads all outputs 1 time unit after the next rising edge, which is exactly when the effect of that nibble is due. Pulses are collected into sticky flags at those sample points, so each check covers the precise clock that its requirement names. A vector table walks complete cycles of both kinds, both directions and varied wait counts, and directed sequences cover start-code holding, aborts, reserved types and bus reset.

// File: rtl/lpc_mon_pkg.sv
package lpc_mon_pkg;

  localparam int unsigned NIB_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_ADDR,
    PH_TAR_A,
    PH_SYNC,
    PH_DATA,
    PH_TAR_B
  } phase_e;

  // Kind encoding follows cycle-type nibble bits [3:2]
  typedef enum logic [1:0] {
    CK_IO   = 2'b00,
    CK_MEM  = 2'b01,
    CK_DMA  = 2'b10,
    CK_RSVD = 2'b11
  } ckind_e;

  localparam logic [NIB_W-1:0] START_TARGET = 4'b0000;
  localparam logic [NIB_W-1:0] START_STOP   = 4'b1111;
  localparam logic [NIB_W-1:0] SYNC_READY   = 4'b0000;
  localparam logic [NIB_W-1:0] SYNC_SHORT   = 4'b0101;
  localparam logic [NIB_W-1:0] SYNC_LONG    = 4'b0110;
  localparam logic [NIB_W-1:0] TAR_IDLE     = 4'b1111;

  function automatic ckind_e kind_of(input logic [1:0] hi);
    return ckind_e'(hi);
  endfunction

  function automatic logic is_wait_sync(input logic [NIB_W-1:0] s);
    return (s == SYNC_SHORT) || (s == SYNC_LONG);
  endfunction

endpackage

// File: rtl/lpc_start_track.sv
module lpc_start_track
  import lpc_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst_n,
  input  logic             bus_frame_n,
  input  logic [NIB_W-1:0] bus_nib,
  output logic [NIB_W-1:0] start_code,
  output logic             lad_chg
);

  logic [NIB_W-1:0] code_q, code_d;
  logic             low_q, low_d;
  logic             chg_q, chg_d;

  // Next state: the held code follows the nibble while the strobe is low
  always_comb begin
    code_d = code_q;
    low_d  = 1'b0;
    chg_d  = 1'b0;
    if (bus_rst_n) begin
      if (!bus_frame_n) begin
        code_d = bus_nib;
        low_d  = 1'b1;
        chg_d  = low_q && (bus_nib != code_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      low_q  <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      low_q  <= low_d;
      chg_q  <= chg_d;
    end
  end

  assign start_code = code_q;
  assign lad_chg    = chg_q;

  AST_CHG_NEEDS_HELD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    lad_chg |-> ($past(!bus_frame_n) && $past(bus_rst_n))); // R3

endmodule

// File: rtl/lpc_phase_fsm.sv
module lpc_phase_fsm
  import lpc_mon_pkg::*;
#(
  parameter int unsigned IO_ADDR_NIBS  = 4,
  parameter int unsigned MEM_ADDR_NIBS = 8,
  parameter int unsigned TAR_LEN       = 2,
  parameter int unsigned DATA_NIBS     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst_n,
  input  logic             bus_frame_n,
  input  logic [NIB_W-1:0] bus_nib,
  input  logic [NIB_W-1:0] start_code,
  output logic             ld_ctdr,
  output logic             sh_addr,
  output logic             sh_data,
  output logic             emit,
  output logic             emit_err,
  output logic [NIB_W-1:0] emit_sync,
  output logic             cyc_mem,
  output logic             cyc_wr,
  output logic             abort_p,
  output logic             ctype_p,
  output logic             tar_p,
  output logic             other_p,
  output logic [NIB_W-1:0] other_code
);

  localparam int unsigned MAX_A   = (MEM_ADDR_NIBS > IO_ADDR_NIBS) ? MEM_ADDR_NIBS : IO_ADDR_NIBS;
  localparam int unsigned MAX_B   = (TAR_LEN > DATA_NIBS) ? TAR_LEN : DATA_NIBS;
  localparam int unsigned CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] IO_LAST   = CNT_W'(IO_ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] MEM_LAST  = CNT_W'(MEM_ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] TAR_LAST  = CNT_W'(TAR_LEN - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);

  phase_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mem_q, mem_d;
  logic             wr_q, wr_d;
  logic             abort_q, abort_d;
  logic             ctype_q, ctype_d;
  logic             tar_q, tar_d;
  logic             other_q, other_d;
  logic [NIB_W-1:0] ocode_q, ocode_d;
  logic             in_mid;
  logic [CNT_W-1:0] addr_last;

  assign in_mid    = (st_q != PH_IDLE) && (st_q != PH_START);
  assign addr_last = mem_q ? MEM_LAST : IO_LAST;

  // Next-state process
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    mem_d     = mem_q;
    wr_d      = wr_q;
    ocode_d   = ocode_q;
    abort_d   = 1'b0;
    ctype_d   = 1'b0;
    tar_d     = 1'b0;
    other_d   = 1'b0;
    ld_ctdr   = 1'b0;
    sh_addr   = 1'b0;
    sh_data   = 1'b0;
    emit      = 1'b0;
    emit_err  = 1'b0;
    emit_sync = SYNC_READY;
    if (!bus_rst_n) begin
      st_d  = PH_IDLE;
      cnt_d = '0;
    end else if (!bus_frame_n) begin
      st_d    = PH_START;
      cnt_d   = '0;
      abort_d = in_mid;
    end else begin
      case (st_q)
        PH_START: begin
          st_d  = PH_IDLE;
          cnt_d = '0;
          if (start_code == START_TARGET) begin
            case (kind_of(bus_nib[3:2]))
              CK_IO: begin
                mem_d   = 1'b0;
                wr_d    = bus_nib[1];
                ld_ctdr = 1'b1;
                st_d    = PH_ADDR;
              end
              CK_MEM: begin
                mem_d   = 1'b1;
                wr_d    = bus_nib[1];
                ld_ctdr = 1'b1;
                st_d    = PH_ADDR;
              end
              CK_RSVD: ctype_d = 1'b1;
              default: ;
            endcase
          end else if (start_code == START_STOP) begin
            abort_d = 1'b1;
          end else begin
            other_d = 1'b1;
            ocode_d = start_code;
          end
        end
        PH_ADDR: begin
          sh_addr = 1'b1;
          if (cnt_q == addr_last) begin
            cnt_d = '0;
            st_d  = wr_q ? PH_DATA : PH_TAR_A;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_DATA: begin
          sh_data = 1'b1;
          if (cnt_q == DATA_LAST) begin
            cnt_d = '0;
            st_d  = wr_q ? PH_TAR_A : PH_TAR_B;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_TAR_A, PH_TAR_B: begin
          tar_d = (bus_nib != TAR_IDLE);
          if (cnt_q == TAR_LAST) begin
            cnt_d = '0;
            if (st_q == PH_TAR_A) begin
              st_d = PH_SYNC;
            end else begin
              st_d = PH_IDLE;
              emit = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_SYNC: begin
          if (is_wait_sync(bus_nib)) begin
            st_d = PH_SYNC;
          end else if (bus_nib == SYNC_READY) begin
            st_d = wr_q ? PH_TAR_B : PH_DATA;
          end else begin
            st_d      = PH_IDLE;
            emit      = 1'b1;
            emit_err  = 1'b1;
            emit_sync = bus_nib;
          end
        end
        default: st_d = PH_IDLE;
      endcase
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PH_IDLE;
      cnt_q   <= '0;
      mem_q   <= 1'b0;
      wr_q    <= 1'b0;
      abort_q <= 1'b0;
      ctype_q <= 1'b0;
      tar_q   <= 1'b0;
      other_q <= 1'b0;
      ocode_q <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      mem_q   <= mem_d;
      wr_q    <= wr_d;
      abort_q <= abort_d;
      ctype_q <= ctype_d;
      tar_q   <= tar_d;
      other_q <= other_d;
      ocode_q <= ocode_d;
    end
  end

  assign cyc_mem    = mem_q;
  assign cyc_wr     = wr_q;
  assign abort_p    = abort_q;
  assign ctype_p    = ctype_q;
  assign tar_p      = tar_q;
  assign other_p    = other_q;
  assign other_code = ocode_q;

  AST_BUSRST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst_n |=> (st_q == PH_IDLE)); // R1

  AST_MIDFRAME_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_n && !bus_frame_n && in_mid) |=> (abort_p && st_q == PH_START)); // R11

  AST_TAR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_TAR_A || st_q == PH_TAR_B) |-> (cnt_q <= TAR_LAST)); // R8

  AST_EMIT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (st_q == PH_TAR_B || st_q == PH_SYNC)); // R13

  AST_WAIT_HOLDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_SYNC && bus_rst_n && bus_frame_n && is_wait_sync(bus_nib)) |=> (st_q == PH_SYNC)); // R9

endmodule

// File: rtl/lpc_rec_build.sv
module lpc_rec_build
  import lpc_mon_pkg::*;
#(
  parameter int unsigned IO_ADDR_NIBS  = 4,
  parameter int unsigned MEM_ADDR_NIBS = 8,
  parameter int unsigned DATA_NIBS     = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NIB_W-1:0]               bus_nib,
  input  logic                           ld_ctdr,
  input  logic                           sh_addr,
  input  logic                           sh_data,
  input  logic                           emit,
  input  logic                           emit_err,
  input  logic [NIB_W-1:0]               emit_sync,
  input  logic                           cyc_mem,
  input  logic                           cyc_wr,
  output logic                           rec_valid,
  output logic                           rec_mem,
  output logic                           rec_wr,
  output logic [MEM_ADDR_NIBS*NIB_W-1:0] rec_addr,
  output logic [DATA_NIBS*NIB_W-1:0]     rec_data,
  output logic [NIB_W-1:0]               rec_sync,
  output logic                           rec_err
);

  localparam int unsigned ADDR_W = MEM_ADDR_NIBS * NIB_W;
  localparam int unsigned DATA_W = DATA_NIBS * NIB_W;
  localparam int unsigned IO_W   = IO_ADDR_NIBS * NIB_W;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              vld_q;
  logic              mem_q, wr_q, err_q;
  logic [ADDR_W-1:0] raddr_q;
  logic [DATA_W-1:0] rdata_q;
  logic [NIB_W-1:0]  rsync_q;

  // Address enters at the bottom (most significant nibble first);
  // data enters at the top (least significant nibble first)
  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    if (ld_ctdr) begin
      addr_d = '0;
    end else if (sh_addr) begin
      addr_d = {addr_q[ADDR_W-NIB_W-1:0], bus_nib};
    end
    if (sh_data) begin
      data_d = {bus_nib, data_q[DATA_W-1:NIB_W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
      vld_q  <= emit;
    end
  end

  // Record fields load only on the emit strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q   <= 1'b0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      raddr_q <= '0;
      rdata_q <= '0;
      rsync_q <= '0;
    end else if (emit) begin
      mem_q   <= cyc_mem;
      wr_q    <= cyc_wr;
      err_q   <= emit_err;
      raddr_q <= addr_q;
      rdata_q <= data_q;
      rsync_q <= emit_sync;
    end
  end

  assign rec_valid = vld_q;
  assign rec_mem   = mem_q;
  assign rec_wr    = wr_q;
  assign rec_addr  = raddr_q;
  assign rec_data  = rdata_q;
  assign rec_sync  = rsync_q;
  assign rec_err   = err_q;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid); // R13

  AST_IO_ADDR_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_mem) |-> ((rec_addr >> IO_W) == '0)); // R5

  AST_ERR_MATCHES_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_err == (rec_sync != SYNC_READY))); // R10

endmodule

// File: rtl/lpc_cycle_mon.sv
module lpc_cycle_mon
  import lpc_mon_pkg::*;
#(
  parameter int unsigned IO_ADDR_NIBS  = 4,
  parameter int unsigned MEM_ADDR_NIBS = 8,
  parameter int unsigned TAR_LEN       = 2,
  parameter int unsigned DATA_NIBS     = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_rst_n,
  input  logic                           bus_frame_n,
  input  logic [3:0]                     bus_nib,
  output logic                           rec_valid,
  output logic                           rec_mem,
  output logic                           rec_wr,
  output logic [MEM_ADDR_NIBS*4-1:0]     rec_addr,
  output logic [DATA_NIBS*4-1:0]         rec_data,
  output logic [3:0]                     rec_sync,
  output logic                           rec_err,
  output logic                           warn_lad_chg,
  output logic                           warn_ctype,
  output logic                           warn_tar,
  output logic                           abort_seen,
  output logic                           other_start,
  output logic [3:0]                     other_code
);

  logic [NIB_W-1:0] start_code;
  logic             ld_ctdr, sh_addr, sh_data;
  logic             emit, emit_err;
  logic [NIB_W-1:0] emit_sync;
  logic             cyc_mem, cyc_wr;

  lpc_start_track u_start (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rst_n   (bus_rst_n),
    .bus_frame_n (bus_frame_n),
    .bus_nib     (bus_nib),
    .start_code  (start_code),
    .lad_chg     (warn_lad_chg)
  );

  lpc_phase_fsm #(
    .IO_ADDR_NIBS  (IO_ADDR_NIBS),
    .MEM_ADDR_NIBS (MEM_ADDR_NIBS),
    .TAR_LEN       (TAR_LEN),
    .DATA_NIBS     (DATA_NIBS)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rst_n   (bus_rst_n),
    .bus_frame_n (bus_frame_n),
    .bus_nib     (bus_nib),
    .start_code  (start_code),
    .ld_ctdr     (ld_ctdr),
    .sh_addr     (sh_addr),
    .sh_data     (sh_data),
    .emit        (emit),
    .emit_err    (emit_err),
    .emit_sync   (emit_sync),
    .cyc_mem     (cyc_mem),
    .cyc_wr      (cyc_wr),
    .abort_p     (abort_seen),
    .ctype_p     (warn_ctype),
    .tar_p       (warn_tar),
    .other_p     (other_start),
    .other_code  (other_code)
  );

  lpc_rec_build #(
    .IO_ADDR_NIBS  (IO_ADDR_NIBS),
    .MEM_ADDR_NIBS (MEM_ADDR_NIBS),
    .DATA_NIBS     (DATA_NIBS)
  ) u_rec (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_nib   (bus_nib),
    .ld_ctdr   (ld_ctdr),
    .sh_addr   (sh_addr),
    .sh_data   (sh_data),
    .emit      (emit),
    .emit_err  (emit_err),
    .emit_sync (emit_sync),
    .cyc_mem   (cyc_mem),
    .cyc_wr    (cyc_wr),
    .rec_valid (rec_valid),
    .rec_mem   (rec_mem),
    .rec_wr    (rec_wr),
    .rec_addr  (rec_addr),
    .rec_data  (rec_data),
    .rec_sync  (rec_sync),
    .rec_err   (rec_err)
  );

  AST_NO_REC_AFTER_BUSRST: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst_n |=> !rec_valid); // R1

  AST_OTHER_NOT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    other_start |-> (other_code != START_TARGET && other_code != START_STOP)); // R12

endmodule

// File: tb/test_lpc_cycle_mon.sv
module test_lpc_cycle_mon;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        mem;
    logic        wr;
    logic        bit0;
    logic [31:0] addr;
    logic [7:0]  data;
    logic [3:0]  nwait;
    logic [3:0]  sync;
    logic        tarbad;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b1, 1'b0, 32'h0000_1234, 8'hA5, 4'd0, 4'h0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 32'h0000_BEEF, 8'h3C, 4'd2, 4'h0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 32'h8765_4321, 8'h96, 4'd1, 4'h0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 32'hFFFF_0010, 8'h01, 4'd3, 4'h0, 1'b1},
    '{1'b0, 1'b0, 1'b0, 32'h0000_0080, 8'h00, 4'd1, 4'hA, 1'b0},
    '{1'b1, 1'b1, 1'b0, 32'h0000_0001, 8'h5A, 4'd0, 4'h9, 1'b0}
  };

  logic        clk;
  logic        rst_n, bus_rst_n, bus_frame_n;
  logic [3:0]  bus_nib;
  logic        rec_valid, rec_mem, rec_wr, rec_err;
  logic [31:0] rec_addr;
  logic [7:0]  rec_data;
  logic [3:0]  rec_sync;
  logic        warn_lad_chg, warn_ctype, warn_tar, abort_seen, other_start;
  logic [3:0]  other_code;

  int n_checks = 0;
  int n_errors = 0;

  int          n_rec;
  logic        r_mem, r_wr, r_err;
  logic [31:0] r_addr;
  logic [7:0]  r_data;
  logic [3:0]  r_sync;
  logic        s_chg, s_ctype, s_tar, s_abort, s_other;
  logic [3:0]  s_ocode;

  lpc_cycle_mon i_lpc_cycle_mon (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rst_n    (bus_rst_n),
    .bus_frame_n  (bus_frame_n),
    .bus_nib      (bus_nib),
    .rec_valid    (rec_valid),
    .rec_mem      (rec_mem),
    .rec_wr       (rec_wr),
    .rec_addr     (rec_addr),
    .rec_data     (rec_data),
    .rec_sync     (rec_sync),
    .rec_err      (rec_err),
    .warn_lad_chg (warn_lad_chg),
    .warn_ctype   (warn_ctype),
    .warn_tar     (warn_tar),
    .abort_seen   (abort_seen),
    .other_start  (other_start),
    .other_code   (other_code)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_seen();
    n_rec = 0; s_chg = 0; s_ctype = 0; s_tar = 0; s_abort = 0; s_other = 0; s_ocode = '0;
  endtask

  // Drive at the falling edge; read results 1 unit after the sampling edge
  task automatic tick(input logic fr, input logic [3:0] nib);
    @(negedge clk);
    bus_frame_n = fr;
    bus_nib     = nib;
    @(posedge clk);
    #1;
    if (rec_valid) begin
      n_rec++;
      r_mem = rec_mem; r_wr = rec_wr; r_addr = rec_addr;
      r_data = rec_data; r_sync = rec_sync; r_err = rec_err;
    end
    if (warn_lad_chg) s_chg = 1;
    if (warn_ctype)   s_ctype = 1;
    if (warn_tar)     s_tar = 1;
    if (abort_seen)   s_abort = 1;
    if (other_start) begin s_other = 1; s_ocode = other_code; end
  endtask

  task automatic waits(input logic [3:0] n);
    for (int w = 0; w < int'(n); w++) tick(1'b1, (w % 2 == 1) ? 4'h6 : 4'h5);
  endtask

  task automatic run_cycle(input vec_t v, input bit skip_start);
    int n;
    n = v.mem ? 8 : 4;
    if (!skip_start) tick(1'b0, 4'h0);
    tick(1'b1, {v.mem ? 2'b01 : 2'b00, v.wr, v.bit0});
    for (int i = 0; i < n; i++) tick(1'b1, v.addr[(n-1-i)*4 +: 4]);
    if (v.wr) begin
      tick(1'b1, v.data[3:0]);
      tick(1'b1, v.data[7:4]);
      tick(1'b1, v.tarbad ? 4'h7 : 4'hF);
      tick(1'b1, 4'hF);
      waits(v.nwait);
      tick(1'b1, v.sync);
      if (v.sync == 4'h0) begin
        tick(1'b1, 4'hF);
        tick(1'b1, 4'hF);
      end
    end else begin
      tick(1'b1, v.tarbad ? 4'h7 : 4'hF);
      tick(1'b1, 4'hF);
      waits(v.nwait);
      tick(1'b1, v.sync);
      if (v.sync == 4'h0) begin
        tick(1'b1, v.data[3:0]);
        tick(1'b1, v.data[7:4]);
        tick(1'b1, 4'hF);
        tick(1'b1, 4'hF);
      end
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL R13 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    vec_t tv;
    rst_n = 1'b0; bus_rst_n = 1'b1; bus_frame_n = 1'b1; bus_nib = 4'hF;
    clear_seen();
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check("R1 valid in reset", rec_valid, 0);
    check("R1 flags in reset", {warn_lad_chg, warn_ctype, warn_tar, abort_seen, other_start}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick(1'b1, 4'hF);
    tick(1'b1, 4'hF);
    check("R1 idle after reset", {n_rec, s_abort, s_other}, 0);

    // Table of complete cycles
    for (int i = 0; i < 6; i++) begin
      vec_t v;
      v = VECS[i];
      clear_seen();
      run_cycle(v, 1'b0);
      check("R13 one record per cycle", n_rec, 1);
      check("R5 record kind", r_mem, v.mem);
      check("R5 record address", r_addr, v.addr);
      check(v.wr ? "R6 record direction" : "R7 record direction", r_wr, v.wr);
      if (v.sync == 4'h0)
        check(v.wr ? "R6 write data" : "R7 read data", r_data, v.data);
      check(v.sync == 4'h0 ? "R9 final sync" : "R10 final sync", r_sync, v.sync);
      check("R10 error flag", r_err, (v.sync != 4'h0));
      check("R8 turnaround warning", s_tar, v.tarbad);
      check("R11 no abort in clean cycle", s_abort, 0);
      tick(1'b1, 4'hF);
      check("R13 valid drops", rec_valid, 0);
    end

    // R2/R3: held strobe with a changing nibble; last nibble is the code
    clear_seen();
    tick(1'b0, 4'h5);
    tick(1'b0, 4'h0);
    check("R3 nibble change warning", s_chg, 1);
    tv = VECS[0];
    run_cycle(tv, 1'b1);
    check("R2 last start nibble used", {n_rec, r_addr}, {32'd1, 32'h0000_1234});

    // R2/R12: last start nibble non-target
    clear_seen();
    tick(1'b0, 4'h0);
    tick(1'b0, 4'hD);
    tick(1'b1, 4'h2);
    check("R12 other start pulse", {s_other, s_ocode}, {1'b1, 4'hD});
    repeat (6) tick(1'b1, 4'h0);
    check("R2 no record for non-target", n_rec, 0);

    // R12: stop code
    clear_seen();
    tick(1'b0, 4'hF);
    tick(1'b1, 4'h0);
    check("R12 stop start code", {s_abort, s_other}, 2'b10);

    // R4: reserved kinds, bit 0 ignored
    clear_seen();
    tick(1'b0, 4'h0);
    tick(1'b1, 4'hC);
    repeat (4) tick(1'b1, 4'h0);
    check("R4 reserved type warning", s_ctype, 1);
    clear_seen();
    tick(1'b0, 4'h0);
    tick(1'b1, 4'hF);
    repeat (12) tick(1'b1, 4'h0);
    check("R4 reserved type with bit0", {s_ctype, n_rec}, {1'b1, 32'd0});

    // R4: DMA kind is neither recorded nor flagged
    clear_seen();
    tick(1'b0, 4'h0);
    tick(1'b1, 4'h8);
    repeat (12) tick(1'b1, 4'h0);
    check("R4 DMA silent", {s_ctype, n_rec}, {1'b0, 32'd0});

    // R11: frame strobe mid-address aborts and restarts
    clear_seen();
    tick(1'b0, 4'h0);
    tick(1'b1, 4'h0);
    tick(1'b1, 4'h1);
    tick(1'b1, 4'h2);
    tick(1'b0, 4'h0);
    check("R11 abort pulse", {s_abort, n_rec}, {1'b1, 32'd0});
    tv = VECS[1];
    run_cycle(tv, 1'b1);
    check("R11 restart record", {n_rec, r_addr}, {32'd1, 32'h0000_BEEF});

    // R1: bus reset in the middle of a cycle
    clear_seen();
    tick(1'b0, 4'h0);
    tick(1'b1, 4'h2);
    tick(1'b1, 4'h1);
    bus_rst_n = 1'b0;
    tick(1'b1, 4'h2);
    bus_rst_n = 1'b1;
    tick(1'b1, 4'h3);
    tick(1'b1, 4'h4);
    tick(1'b1, 4'h5);
    tick(1'b1, 4'h6);
    tick(1'b1, 4'hF);
    tick(1'b1, 4'hF);
    tick(1'b1, 4'h0);
    tick(1'b1, 4'hF);
    tick(1'b1, 4'hF);
    check("R1 bus reset discards cycle", {n_rec, s_abort}, 0);

    summary();
    $finish;
  end

endmodule